// File: doc/BRIEF.md
# Cache Line Condition Controller with Parity-Guarded State Bits

This block keeps the coherence condition of every line in a cache's indexed array. Each line holds three condition bits (valid, shared, dirty) and a fourth bit that carries even parity over those three. A single command port applies one operation per cycle to one line: a lookup, a fill, a write from the local processor, a notice that another cache has taken a copy, or a notice that another cache wants the line invalidated. The block answers each command with the resulting condition of the line and raises the memory-side actions the coherence scheme needs.

The scheme is write-invalidate. A local write to a line that other caches may hold goes through to memory, broadcasts an invalidate, and leaves the local copy clean and unshared. A fill that would evict a dirty line first raises a write-back request and holds the command port for one cycle. Stored bits that fail the parity check are reported, and the line is then treated as empty. Line data, tags and bus signalling are handled elsewhere. A raw bit-flip operation lets integration and test logic corrupt a stored word on purpose.

Top module: `line_cond_ctrl`

## Requirements
- R1: The stored word of a line is [3]=parity P, [2]=valid V, [1]=shared S, [0]=dirty D. `resp_state` codes are 0 Invalid, 1 Clean, 2 Dirty, 3 Clean Shared, 4 Dirty Shared. V=0 reads as Invalid whatever S and D hold. With V=1 the {S,D} pairs 00, 01, 10 and 11 read as Clean, Dirty, Clean Shared and Dirty Shared. After reset every line reads Invalid.
- R2: Every state update rewrites P so that P^V^S^D is 0.
- R3: When a command finds a stored word with odd parity, `parity_error` is 1 in that command's response. The line is treated as Invalid: a lookup reports Invalid, and a local write or remote share leaves the word unchanged.
- R4: A fill leaves the line Clean, or Clean Shared when `cmd_shared` is 1.
- R5: A local write to a Clean or Dirty line makes it Dirty, with `mem_wr` and `inv_out` low.
- R6: A local write to a Clean Shared or Dirty Shared line raises `mem_wr` and `inv_out` in its response and leaves the line Clean.
- R7: A remote share turns Clean into Clean Shared and Dirty into Dirty Shared. It leaves lines that are already shared unchanged.
- R8: No single command changes Clean Shared into Dirty Shared, or Dirty Shared into Clean Shared.
- R9: A remote invalidate leaves the line Invalid with valid parity, so a later lookup reports Invalid without `parity_error`.
- R10: A fill into a line that reads Dirty or Dirty Shared raises `wb_req` for one cycle, with `wb_idx` set to that line. `cmd_ready` is low in that cycle, and the fill's response follows in the next cycle.
- R11: A local write or remote share to an Invalid line reports Invalid and leaves the line Invalid.
- R12: Op codes are 0 lookup, 1 fill, 2 local write, 3 remote share, 4 remote invalidate, 5 flip. An accepted command other than flip gives exactly one response cycle (`resp_valid`, with `resp_idx`), one cycle after acceptance. A flip XORs `cmd_flip` into the stored word without fixing parity and gives no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle when high |
| cmd_op | input | 3 | Operation code |
| cmd_idx | input | IDX_W | Line index |
| cmd_shared | input | 1 | Fill brings the line in shared |
| cmd_flip | input | 4 | Bit mask for the flip operation |
| resp_valid | output | 1 | Response present |
| resp_idx | output | IDX_W | Line the response belongs to |
| resp_state | output | 3 | Resulting line condition |
| parity_error | output | 1 | Stored word failed parity |
| mem_wr | output | 1 | Write-through to memory required |
| inv_out | output | 1 | Invalidate to be broadcast to other caches |
| wb_req | output | 1 | Write-back of an evicted dirty line |
| wb_idx | output | IDX_W | Line to be written back |

## Verification
The bench builds the block with eight lines. This lets one run drive every line through each condition, reuse lines as victims for dirty and dirty-shared evictions, and corrupt chosen lines with flip masks that break parity, clear valid alone, or leave parity intact. Back-to-back commands around a write-back check that the stalled cycle drops no command and adds no response.

// File: rtl/line_cond_pkg.sv
package line_cond_pkg;

  localparam int WORD_W = 4;
  localparam int P_BIT  = 3;
  localparam int V_BIT  = 2;
  localparam int S_BIT  = 1;
  localparam int D_BIT  = 0;

  typedef enum logic [2:0] {
    LS_INVALID   = 3'd0,
    LS_CLEAN     = 3'd1,
    LS_DIRTY     = 3'd2,
    LS_CLEAN_SH  = 3'd3,
    LS_DIRTY_SH  = 3'd4
  } lstate_e;

  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_FILL   = 3'd1,
    OP_LWRITE = 3'd2,
    OP_RSHARE = 3'd3,
    OP_RINV   = 3'd4,
    OP_FLIP   = 3'd5
  } lop_e;

  function automatic logic [WORD_W-1:0] make_word(logic v, logic s, logic d);
    make_word = {v ^ s ^ d, v, s, d};
  endfunction

endpackage

// File: rtl/cond_store.sv
module cond_store
  import line_cond_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word,
  input  logic              we,
  input  logic              wr_raw,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_word
);

  logic [WORD_W-1:0] words_q [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic hit_en;
    assign hit_en = we && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        words_q[g] <= '0;
      end else if (hit_en) begin
        words_q[g] <= wr_word;
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (rd_idx == IDX_W'(i)) rd_word = words_q[i];
    end
  end

  // R2: every non-raw update stores a word with even parity
  assert_even_parity_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !wr_raw) |-> (^wr_word == 1'b0));

endmodule

// File: rtl/cond_decode.sv
module cond_decode
  import line_cond_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output lstate_e           state,
  output logic              par_bad
);

  always_comb begin
    par_bad = ^word;
    state   = LS_INVALID;
    if (!par_bad && word[V_BIT]) begin
      unique case ({word[S_BIT], word[D_BIT]})
        2'b00:   state = LS_CLEAN;
        2'b01:   state = LS_DIRTY;
        2'b10:   state = LS_CLEAN_SH;
        default: state = LS_DIRTY_SH;
      endcase
    end
  end

endmodule

// File: rtl/cond_next.sv
module cond_next
  import line_cond_pkg::*;
(
  input  lop_e              op,
  input  lstate_e           state,
  input  logic [WORD_W-1:0] word,
  input  logic              fill_shared,
  input  logic [WORD_W-1:0] flip_mask,
  output logic [WORD_W-1:0] new_word,
  output logic              wr_en,
  output logic              need_wb,
  output logic              mem_wr,
  output logic              inv,
  output logic              has_resp,
  output lstate_e           resp_state
);

  always_comb begin
    new_word   = word;
    wr_en      = 1'b0;
    need_wb    = 1'b0;
    mem_wr     = 1'b0;
    inv        = 1'b0;
    has_resp   = 1'b1;
    resp_state = state;
    unique case (op)
      OP_FILL: begin
        need_wb    = (state == LS_DIRTY) || (state == LS_DIRTY_SH);
        new_word   = make_word(1'b1, fill_shared, 1'b0);
        wr_en      = !need_wb;
        resp_state = fill_shared ? LS_CLEAN_SH : LS_CLEAN;
      end
      OP_LWRITE: begin
        if (state == LS_CLEAN || state == LS_DIRTY) begin
          new_word   = make_word(1'b1, 1'b0, 1'b1);
          wr_en      = 1'b1;
          resp_state = LS_DIRTY;
        end else if (state == LS_CLEAN_SH || state == LS_DIRTY_SH) begin
          new_word   = make_word(1'b1, 1'b0, 1'b0);
          wr_en      = 1'b1;
          mem_wr     = 1'b1;
          inv        = 1'b1;
          resp_state = LS_CLEAN;
        end
      end
      OP_RSHARE: begin
        if (state == LS_CLEAN) begin
          new_word   = make_word(1'b1, 1'b1, 1'b0);
          wr_en      = 1'b1;
          resp_state = LS_CLEAN_SH;
        end else if (state == LS_DIRTY) begin
          new_word   = make_word(1'b1, 1'b1, 1'b1);
          wr_en      = 1'b1;
          resp_state = LS_DIRTY_SH;
        end
      end
      OP_RINV: begin
        new_word   = make_word(1'b0, word[S_BIT], word[D_BIT]);
        wr_en      = 1'b1;
        resp_state = LS_INVALID;
      end
      OP_FLIP: begin
        new_word = word ^ flip_mask;
        wr_en    = 1'b1;
        has_resp = 1'b0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/line_cond_ctrl.sv
module line_cond_ctrl
  import line_cond_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic              cmd_shared,
  input  logic [3:0]        cmd_flip,
  output logic              resp_valid,
  output logic [IDX_W-1:0]  resp_idx,
  output logic [2:0]        resp_state,
  output logic              parity_error,
  output logic              mem_wr,
  output logic              inv_out,
  output logic              wb_req,
  output logic [IDX_W-1:0]  wb_idx
);

  logic              busy_q, busy_d;
  logic [IDX_W-1:0]  pend_idx_q;
  logic              pend_sh_q;
  logic              pend_en;

  logic [WORD_W-1:0] rd_word, nx_word, st_wdata;
  logic              st_we, st_raw;
  logic [IDX_W-1:0]  st_widx;
  lstate_e           cur_state, nx_resp;
  logic              par_bad, nx_wr, nx_wb, nx_mem, nx_inv, nx_has;
  lop_e              op;
  logic              accept;

  logic              rv_d, pe_d, mw_d, iv_d, wb_d;
  logic [IDX_W-1:0]  ri_d, wi_d;
  logic [2:0]        rs_d;

  assign op        = lop_e'(cmd_op);
  assign cmd_ready = !busy_q;
  assign accept    = cmd_valid && cmd_ready;

  cond_store #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (cmd_idx),
    .rd_word (rd_word),
    .we      (st_we),
    .wr_raw  (st_raw),
    .wr_idx  (st_widx),
    .wr_word (st_wdata)
  );

  cond_decode u_dec (
    .word    (rd_word),
    .state   (cur_state),
    .par_bad (par_bad)
  );

  cond_next u_next (
    .op          (op),
    .state       (cur_state),
    .word        (rd_word),
    .fill_shared (cmd_shared),
    .flip_mask   (cmd_flip),
    .new_word    (nx_word),
    .wr_en       (nx_wr),
    .need_wb     (nx_wb),
    .mem_wr      (nx_mem),
    .inv         (nx_inv),
    .has_resp    (nx_has),
    .resp_state  (nx_resp)
  );

  // next-state logic
  always_comb begin
    busy_d   = 1'b0;
    pend_en  = 1'b0;
    st_we    = 1'b0;
    st_raw   = 1'b0;
    st_widx  = cmd_idx;
    st_wdata = nx_word;
    rv_d     = 1'b0;
    ri_d     = cmd_idx;
    rs_d     = nx_resp;
    pe_d     = 1'b0;
    mw_d     = 1'b0;
    iv_d     = 1'b0;
    wb_d     = 1'b0;
    wi_d     = cmd_idx;
    if (busy_q) begin
      st_we    = 1'b1;
      st_widx  = pend_idx_q;
      st_wdata = make_word(1'b1, pend_sh_q, 1'b0);
      rv_d     = 1'b1;
      ri_d     = pend_idx_q;
      rs_d     = pend_sh_q ? LS_CLEAN_SH : LS_CLEAN;
    end else if (accept) begin
      if (nx_wb) begin
        busy_d  = 1'b1;
        pend_en = 1'b1;
        wb_d    = 1'b1;
      end else begin
        st_we  = nx_wr;
        st_raw = (op == OP_FLIP);
        rv_d   = nx_has;
        pe_d   = nx_has && par_bad;
        mw_d   = nx_mem;
        iv_d   = nx_inv;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q       <= 1'b0;
      pend_idx_q   <= '0;
      pend_sh_q    <= 1'b0;
      resp_valid   <= 1'b0;
      resp_idx     <= '0;
      resp_state   <= LS_INVALID;
      parity_error <= 1'b0;
      mem_wr       <= 1'b0;
      inv_out      <= 1'b0;
      wb_req       <= 1'b0;
      wb_idx       <= '0;
    end else begin
      busy_q       <= busy_d;
      if (pend_en) begin
        pend_idx_q <= cmd_idx;
        pend_sh_q  <= cmd_shared;
      end
      resp_valid   <= rv_d;
      resp_idx     <= ri_d;
      resp_state   <= rs_d;
      parity_error <= pe_d;
      mem_wr       <= mw_d;
      inv_out      <= iv_d;
      wb_req       <= wb_d;
      wb_idx       <= wi_d;
    end
  end

  // R10: eviction stalls the port and the fill answers next cycle
  assert_wb_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> !cmd_ready);
  assert_wb_then_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |=> (resp_valid && (resp_state == LS_CLEAN || resp_state == LS_CLEAN_SH)));
  // R6: write-through always comes with an invalidate and a clean line
  assert_wt_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (resp_valid && inv_out && resp_state == LS_CLEAN));
  // R3: a parity error is only reported within a response
  assert_perr_resp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    parity_error |-> resp_valid);
  // R8: no direct move between the two shared conditions
  assert_no_cs_to_ds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cur_state == LS_CLEAN_SH) |=> (resp_state != LS_DIRTY_SH));
  assert_no_ds_to_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cur_state == LS_DIRTY_SH && op != OP_FILL) |=> (resp_state != LS_CLEAN_SH));
  // R12: flip produces no response
  assert_flip_silent_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_FLIP) |=> !resp_valid);

endmodule

// File: tb/line_cond_ctrl_tb_top.sv
`timescale 1ns/1ps
module line_cond_ctrl_tb_top;

  localparam int NL = 8;
  localparam int IW = 3;

  logic clk, rst_n;
  logic cmd_valid, cmd_ready, cmd_shared;
  logic [2:0] cmd_op;
  logic [IW-1:0] cmd_idx;
  logic [3:0] cmd_flip;
  logic resp_valid, parity_error, mem_wr, inv_out, wb_req;
  logic [IW-1:0] resp_idx, wb_idx;
  logic [2:0] resp_state;

  line_cond_ctrl #(.NUM_LINES(NL), .IDX_W(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_shared(cmd_shared), .cmd_flip(cmd_flip),
    .resp_valid(resp_valid), .resp_idx(resp_idx), .resp_state(resp_state),
    .parity_error(parity_error), .mem_wr(mem_wr), .inv_out(inv_out),
    .wb_req(wb_req), .wb_idx(wb_idx)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [7:0]    req;
    logic [IW-1:0] idx;
    logic [2:0]    st;
    logic          perr;
    logic          mw;
    logic          wb;
  } exp_t;

  exp_t expq[$];
  logic [3:0] mdl [NL];
  int checks = 0, fails = 0, cycles = 0;
  logic wb_seen;
  logic [IW-1:0] wb_seen_idx;
  bit done = 0;

  task automatic chk(input bit ok, input int req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] dec(input logic [3:0] w);
    if (^w) return 3'd0;
    if (!w[2]) return 3'd0;
    case (w[1:0])
      2'b00: return 3'd1;
      2'b01: return 3'd2;
      2'b10: return 3'd3;
      default: return 3'd4;
    endcase
  endfunction

  // driver: computes expectation from the requirements and queues it
  task automatic send(input logic [2:0] op, input int idx, input logic sh,
                      input logic [3:0] fl, input int req);
    exp_t e;
    logic [3:0] w;
    logic [2:0] s;
    @(negedge clk);
    while (!cmd_ready) begin
      cmd_valid = 1'b0;
      @(negedge clk);
    end
    cmd_valid = 1'b1; cmd_op = op; cmd_idx = IW'(idx); cmd_shared = sh; cmd_flip = fl;
    w = mdl[idx];
    s = dec(w);
    e = '0;
    e.req = 8'(req); e.idx = IW'(idx); e.perr = ^w; e.st = s;
    case (op)
      3'd1: begin
        e.wb = (s == 3'd2 || s == 3'd4);
        if (e.wb) e.perr = 1'b0;
        mdl[idx] = sh ? 4'b0110 : 4'b1100;
        e.st = sh ? 3'd3 : 3'd1;
      end
      3'd2: begin
        if (s == 3'd1 || s == 3'd2) begin mdl[idx] = 4'b0101; e.st = 3'd2; end
        else if (s == 3'd3 || s == 3'd4) begin mdl[idx] = 4'b1100; e.st = 3'd1; e.mw = 1'b1; end
      end
      3'd3: begin
        if (s == 3'd1) begin mdl[idx] = 4'b0110; e.st = 3'd3; end
        else if (s == 3'd2) begin mdl[idx] = 4'b1111; e.st = 3'd4; end
      end
      3'd4: begin
        mdl[idx] = {w[1] ^ w[0], 1'b0, w[1], w[0]};
        e.st = 3'd0;
      end
      3'd5: mdl[idx] = w ^ fl;
      default: ;
    endcase
    if (op != 3'd5) expq.push_back(e);
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expectations as responses appear
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (wb_req) begin
        chk(cmd_ready == 1'b0, 10, "cmd_ready during wb_req", cmd_ready, 0);
        wb_seen = 1'b1;
        wb_seen_idx = wb_idx;
      end
      if (resp_valid) begin
        if (expq.size() == 0) begin
          chk(1'b0, 12, "unexpected response", 1, 0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          chk(resp_idx == e.idx, int'(e.req), "resp_idx", resp_idx, e.idx);
          chk(resp_state == e.st, int'(e.req), "resp_state", resp_state, e.st);
          chk(parity_error == e.perr, int'(e.req), "parity_error", parity_error, e.perr);
          chk(mem_wr == e.mw && inv_out == e.mw, int'(e.req), "mem_wr/inv_out", {mem_wr, inv_out}, {e.mw, e.mw});
          chk(wb_seen == e.wb, int'(e.req), "write-back seen", wb_seen, e.wb);
          if (e.wb) chk(wb_seen_idx == e.idx, 10, "wb_idx", wb_seen_idx, e.idx);
          wb_seen = 1'b0;
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      chk(1'b0, 12, "watchdog expired", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NL; i++) mdl[i] = 4'b0000;
    wb_seen = 1'b0; wb_seen_idx = '0;
    cmd_valid = 1'b0; cmd_op = 3'd0; cmd_idx = '0; cmd_shared = 1'b0; cmd_flip = 4'h0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cmd_ready == 1'b1, 1, "cmd_ready after reset", cmd_ready, 1);
    chk(resp_valid == 1'b0 && wb_req == 1'b0, 1, "idle outputs after reset", {resp_valid, wb_req}, 0);
    rst_n = 1'b1;
    send(3'd0, 0, 0, 0, 1);      // R1 lookup of empty line
    send(3'd1, 0, 0, 0, 4);      // R4 fill clean
    send(3'd0, 0, 0, 0, 1);      // R1 Clean decode
    send(3'd1, 1, 1, 0, 4);      // R4 fill shared
    send(3'd2, 0, 0, 0, 5);      // R5 Clean -> Dirty
    send(3'd2, 0, 0, 0, 5);      // R5 Dirty stays Dirty
    send(3'd3, 0, 0, 0, 7);      // R7 Dirty -> Dirty Shared
    send(3'd3, 0, 0, 0, 7);      // R7 shared stays
    send(3'd2, 0, 0, 0, 6);      // R6 Dirty Shared write-through
    send(3'd2, 1, 0, 0, 6);      // R6 Clean Shared write-through
    send(3'd3, 1, 0, 0, 8);      // R8 Clean -> Clean Shared only
    send(3'd3, 1, 0, 0, 8);      // R8 Clean Shared stays
    send(3'd2, 2, 0, 0, 11);     // R11 write to invalid
    send(3'd3, 2, 0, 0, 11);     // R11 share of invalid
    send(3'd0, 2, 0, 0, 11);
    send(3'd1, 3, 0, 0, 4);
    send(3'd2, 3, 0, 0, 5);
    send(3'd1, 3, 1, 0, 10);     // R10 eviction of Dirty
    send(3'd0, 3, 0, 0, 10);     // back-to-back after stall
    send(3'd1, 4, 0, 0, 4);
    send(3'd2, 4, 0, 0, 5);
    send(3'd3, 4, 0, 0, 7);
    send(3'd1, 4, 0, 0, 10);     // R10 eviction of Dirty Shared
    send(3'd1, 5, 0, 0, 4);
    send(3'd2, 5, 0, 0, 5);
    send(3'd3, 5, 0, 0, 7);
    send(3'd4, 5, 0, 0, 9);      // R9 invalidate Dirty Shared
    send(3'd0, 5, 0, 0, 9);      // R9 no parity error afterwards
    send(3'd4, 1, 0, 0, 9);
    send(3'd0, 1, 0, 0, 9);
    send(3'd5, 0, 0, 4'b0100, 12); // R12 flip V only: parity breaks
    send(3'd0, 0, 0, 0, 3);      // R3 lookup reports Invalid + error
    send(3'd2, 0, 0, 0, 3);      // R3 write leaves word alone
    send(3'd3, 0, 0, 0, 3);      // R3 share leaves word alone
    send(3'd0, 0, 0, 0, 3);
    send(3'd1, 0, 0, 0, 3);      // R3 fill over corrupted line
    send(3'd0, 0, 0, 0, 2);      // R2 parity restored
    send(3'd1, 6, 0, 0, 4);
    send(3'd2, 6, 0, 0, 5);
    send(3'd5, 6, 0, 4'b1000, 12); // R12 flip parity bit of Dirty line
    send(3'd1, 6, 1, 0, 3);      // R3 no write-back for bad-parity victim
    send(3'd1, 7, 0, 0, 4);
    send(3'd5, 7, 0, 4'b0110, 12); // even flip: parity still passes
    send(3'd0, 7, 0, 0, 1);      // R1 V=0 with S set reads Invalid
    send(3'd4, 7, 0, 0, 9);
    send(3'd0, 7, 0, 0, 2);
    idle(6);
    chk(expq.size() == 0, 12, "responses outstanding", expq.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule